// File: doc/BRIEF.md
# Two-Sided Hardware Semaphore Bank

This block keeps a small bank of hardware semaphores that two independent bus sides, a host side and a target side, use to agree on who may touch a shared resource. Each side has its own address, write-enable, single write-data bit and read-enable. Writing 0 to a semaphore asks for it. Writing 1 gives it back, or withdraws a request that is still waiting. A side learns whether it holds a semaphore by reading it. The flag field of the read word is all zeros when the reader holds the semaphore and all ones when it does not.

Ownership goes to the first side that asks. A side that asks while the other side holds the semaphore is not turned away for good. Its request stays latched, and the semaphore passes to it in the same clock edge at which the holder releases, with no further write. When both sides ask for a free semaphore in the same cycle, the host side wins and the target request is latched as pending. Each semaphore keeps its own state, so software can pass ownership of separate buffer regions back and forth independently.

Top module: `sem_bank`

## Requirements
- R1: After a synchronous active-high reset every semaphore is free with no pending request, and both read ports return 0xFFFF in the flag field (bits 15:0).
- R2: A write of 0 (write-enable high, write-data bit 0) to a free semaphore gives it to the writing side at that clock edge. A later read by that side returns 0x0000 in bits 15:0, and a read by the other side returns 0xFFFF.
- R3: Read data is registered. It changes at the edge where read-enable is sampled high and shows the semaphore state from before any write at that same edge. While read-enable is low, read data holds its last value.
- R4: Read words are RD_W = 32 bits wide. Bits 31:16 are always 0, and bits 15:0 are either all zeros or all ones.
- R5: A write of 0 to a semaphore held by the other side leaves the holder unchanged and latches a pending request for the writer.
- R6: When the holder writes 1 while the other side has a pending request, or asks in that same cycle, ownership passes to the other side at that edge. Without such a request the semaphore becomes free.
- R7: A write of 1 by a side that is only waiting cancels its pending request. A later release by the holder then leaves the semaphore free.
- R8: When both sides write 0 to a free semaphore in the same cycle, the host side gets it and the target request becomes pending.
- R9: A write of 0 by the current holder changes nothing. A write of 1 by a side that neither holds nor waits for the semaphore changes nothing.
- R10: There are NUM_SEM = 8 semaphores, selected by address values 0 to 7 on each side. A write to one semaphore never changes another.
- R11: The two sides never hold the same semaphore at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | 3 | Host semaphore index for read and write |
| h_wbit | input | 1 | Host write data bit: 0 asks, 1 releases or withdraws |
| h_we | input | 1 | Host write enable |
| h_re | input | 1 | Host read enable |
| h_rdata | output | 32 | Host read word |
| t_addr | input | 3 | Target semaphore index for read and write |
| t_wbit | input | 1 | Target write data bit: 0 asks, 1 releases or withdraws |
| t_we | input | 1 | Target write enable |
| t_re | input | 1 | Target read enable |
| t_rdata | output | 32 | Target read word |

## Verification
A write takes effect at the edge where it is sampled. A read presented one cycle later therefore shows the new state. Read data appears one edge after read-enable is sampled and shows the state from before that edge. The bench drives every stimulus just after a falling edge and samples just after the next falling edge, so each read result is compared in the first cycle it is due.

The sweep first builds each reachable per-semaphore state: free, held by either side, and held with the other side pending. From each state it applies all nine pairings of host and target actions in one cycle. It then reads back all eight semaphores from both sides. A long pseudo-random sequence follows, compared against a model built from the requirements. Directed cases cover the same-cycle read-before-write rule and the hold of read data while read-enable is low.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_TGT  = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_addr_dec.sv
module sem_addr_dec #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = $clog2(NUM_SEM)
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wbit,
  input  logic               we,
  output logic [NUM_SEM-1:0] ask,
  output logic [NUM_SEM-1:0] drop
);
  // One-hot split of a side's write into an ask strobe and a drop strobe.
  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sel
    logic hit;
    assign hit     = we && (addr == ADDR_W'(i));
    assign ask[i]  = hit && !wbit;
    assign drop[i] = hit &&  wbit;
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ask_h,
  input  logic drop_h,
  input  logic ask_t,
  input  logic drop_t,
  output logic held_h,
  output logic held_t
);
  owner_e owner_q, owner_d;
  logic   wait_h_q, wait_h_d;
  logic   wait_t_q, wait_t_d;

  always_comb begin
    owner_d  = owner_q;
    wait_h_d = wait_h_q;
    wait_t_d = wait_t_q;
    unique case (owner_q)
      OWN_NONE: begin
        wait_h_d = 1'b0;
        wait_t_d = 1'b0;
        if (ask_h) begin
          owner_d  = OWN_HOST;       // host wins a same-cycle tie
          wait_t_d = ask_t;
        end else if (ask_t) begin
          owner_d  = OWN_TGT;
        end
      end
      OWN_HOST: begin
        if (drop_h) begin
          owner_d  = (ask_t || (wait_t_q && !drop_t)) ? OWN_TGT : OWN_NONE;
          wait_h_d = 1'b0;
          wait_t_d = 1'b0;
        end else if (ask_t) begin
          wait_t_d = 1'b1;
        end else if (drop_t) begin
          wait_t_d = 1'b0;
        end
      end
      OWN_TGT: begin
        if (drop_t) begin
          owner_d  = (ask_h || (wait_h_q && !drop_h)) ? OWN_HOST : OWN_NONE;
          wait_h_d = 1'b0;
          wait_t_d = 1'b0;
        end else if (ask_h) begin
          wait_h_d = 1'b1;
        end else if (drop_h) begin
          wait_h_d = 1'b0;
        end
      end
      default: begin
        owner_d  = OWN_NONE;
        wait_h_d = 1'b0;
        wait_t_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q  <= OWN_NONE;
      wait_h_q <= 1'b0;
      wait_t_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      wait_h_q <= wait_h_d;
      wait_t_q <= wait_t_d;
    end
  end

  assign held_h = (owner_q == OWN_HOST);
  assign held_t = (owner_q == OWN_TGT);

  AST_IDLE_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_NONE) |-> (!wait_h_q && !wait_t_q)); // R1
  AST_GRANT_FREE: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_NONE && !ask_h && ask_t) |=> (owner_q == OWN_TGT)); // R2
  AST_LATCH_WAIT: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_HOST && !drop_h && ask_t) |=> (owner_q == OWN_HOST && wait_t_q)); // R5
  AST_HANDOFF: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_TGT && drop_t && wait_h_q && !drop_h) |=> (owner_q == OWN_HOST)); // R6
  AST_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_HOST && !drop_h && drop_t) |=> !wait_t_q); // R7
  AST_TIE_HOST: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_NONE && ask_h && ask_t) |=> (owner_q == OWN_HOST && wait_t_q)); // R8
  AST_HOLDER_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_TGT && !drop_t) |=> (owner_q == OWN_TGT)); // R9
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = $clog2(NUM_SEM),
  parameter int RD_W    = 32,
  parameter int FLAG_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               re,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SEM-1:0] held,
  output logic [RD_W-1:0]    rdata
);
  localparam int PAD_W = RD_W - FLAG_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= {{PAD_W{1'b0}}, {FLAG_W{1'b1}}};
    end else if (re) begin
      rdata <= {{PAD_W{1'b0}}, {FLAG_W{!held[addr]}}};
    end
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata[RD_W-1:FLAG_W] == '0); // R4
  AST_FLAG_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    (rdata[FLAG_W-1:0] == '0) || (&rdata[FLAG_W-1:0])); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata)); // R3
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = $clog2(NUM_SEM),
  parameter int RD_W    = 32,
  parameter int FLAG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic              h_wbit,
  input  logic              h_we,
  input  logic              h_re,
  output logic [RD_W-1:0]   h_rdata,
  input  logic [ADDR_W-1:0] t_addr,
  input  logic              t_wbit,
  input  logic              t_we,
  input  logic              t_re,
  output logic [RD_W-1:0]   t_rdata
);
  logic [NUM_SEM-1:0] ask_h, drop_h, ask_t, drop_t;
  logic [NUM_SEM-1:0] held_h, held_t;

  sem_addr_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_dec_h (
    .addr(h_addr), .wbit(h_wbit), .we(h_we), .ask(ask_h), .drop(drop_h));
  sem_addr_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_dec_t (
    .addr(t_addr), .wbit(t_wbit), .we(t_we), .ask(ask_t), .drop(drop_t));

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    sem_cell u_cell (
      .clk(clk), .rst(rst),
      .ask_h(ask_h[i]), .drop_h(drop_h[i]),
      .ask_t(ask_t[i]), .drop_t(drop_t[i]),
      .held_h(held_h[i]), .held_t(held_t[i]));
  end

  sem_read_port #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .RD_W(RD_W), .FLAG_W(FLAG_W)) u_rd_h (
    .clk(clk), .rst(rst), .re(h_re), .addr(h_addr), .held(held_h), .rdata(h_rdata));
  sem_read_port #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .RD_W(RD_W), .FLAG_W(FLAG_W)) u_rd_t (
    .clk(clk), .rst(rst), .re(t_re), .addr(t_addr), .held(held_t), .rdata(t_rdata));

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (held_h & held_t) == '0); // R11
  AST_OTHERS_STILL: assert property (@(posedge clk) disable iff (rst)
    (!h_we && !t_we) |=> ($stable(held_h) && $stable(held_t))); // R10
endmodule

// File: tb/sem_bank_tb.sv
module sem_bank_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  h_addr = '0, t_addr = '0;
  logic        h_wbit = 1'b0, t_wbit = 1'b0;
  logic        h_we = 1'b0, t_we = 1'b0, h_re = 1'b0, t_re = 1'b0;
  logic [31:0] h_rdata, t_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int m_own [N];   // 0 free, 1 host, 2 target
  bit m_wh  [N];
  bit m_wt  [N];

  always #5 clk = ~clk;

  sem_bank u_dut (
    .clk(clk), .rst(rst),
    .h_addr(h_addr), .h_wbit(h_wbit), .h_we(h_we), .h_re(h_re), .h_rdata(h_rdata),
    .t_addr(t_addr), .t_wbit(t_wbit), .t_we(t_we), .t_re(t_re), .t_rdata(t_rdata));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Requirement-level model: asking grants a free semaphore (host first on a tie),
  // asking a held one waits, release hands to a waiter, withdraw cancels a wait.
  function automatic void model(input int i, input bit hq, input bit hl, input bit tq, input bit tl);
    if (m_own[i] == 0) begin
      m_wh[i] = 0; m_wt[i] = 0;
      if (hq) begin m_own[i] = 1; m_wt[i] = tq; end
      else if (tq) m_own[i] = 2;
    end else if (m_own[i] == 1) begin
      if (hl) begin m_own[i] = (tq || (m_wt[i] && !tl)) ? 2 : 0; m_wh[i] = 0; m_wt[i] = 0; end
      else if (tq) m_wt[i] = 1;
      else if (tl) m_wt[i] = 0;
    end else begin
      if (tl) begin m_own[i] = (hq || (m_wh[i] && !hl)) ? 1 : 0; m_wh[i] = 0; m_wt[i] = 0; end
      else if (hq) m_wh[i] = 1;
      else if (hl) m_wh[i] = 0;
    end
  endfunction

  // One cycle; act: 0 none, 1 ask (write 0), 2 release (write 1)
  task automatic step(input int ha, input int hact, input int ta, input int tact);
    h_addr = 3'(ha); t_addr = 3'(ta);
    h_we = (hact != 0); h_wbit = (hact == 2);
    t_we = (tact != 0); t_wbit = (tact == 2);
    @(posedge clk);
    for (int i = 0; i < N; i++)
      model(i, hact == 1 && ha == i, hact == 2 && ha == i, tact == 1 && ta == i, tact == 2 && ta == i);
    @(negedge clk);
    h_we = 0; t_we = 0;
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < N; i++) begin
      logic [31:0] eh, et;
      h_addr = 3'(i); t_addr = 3'(i); h_re = 1; t_re = 1;
      @(posedge clk); @(negedge clk);
      h_re = 0; t_re = 0;
      eh = (m_own[i] == 1) ? 32'h0000_0000 : 32'h0000_FFFF;
      et = (m_own[i] == 2) ? 32'h0000_0000 : 32'h0000_FFFF;
      check(h_rdata === eh, tag, h_rdata, eh);
      check(t_rdata === et, tag, t_rdata, et);
    end
  endtask

  task automatic free_all();
    for (int i = 0; i < N; i++) step(i, 2, i, 2);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [31:0] keep;
    for (int i = 0; i < N; i++) begin m_own[i] = 0; m_wh[i] = 0; m_wt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(h_rdata === 32'h0000_FFFF, "R1 reset host read", h_rdata, 32'h0000_FFFF);
    check(t_rdata === 32'h0000_FFFF, "R1 reset target read", t_rdata, 32'h0000_FFFF);
    rst = 0;
    check_all("R1 all free after reset");

    // R8 tie, then R6 hand-off to latched target
    step(3, 1, 3, 1);
    check_all("R8 host wins tie");
    step(3, 2, 0, 0);
    check_all("R6 hand-off to pending target");
    step(0, 0, 3, 2);
    check_all("R6 target release to free");

    // R3: read and write in the same cycle shows the old state
    h_addr = 3'd5; h_we = 1; h_wbit = 0; h_re = 1;
    @(posedge clk); @(negedge clk);
    h_we = 0; h_re = 0; model(5, 1, 0, 0, 0);
    check(h_rdata === 32'h0000_FFFF, "R3 read before same-cycle write", h_rdata, 32'h0000_FFFF);
    keep = h_rdata;
    step(5, 2, 0, 0);
    step(5, 1, 0, 0);
    check(h_rdata === keep, "R3 read data holds while idle", h_rdata, keep);
    check_all("R2 host grant on semaphore 5");

    // R7 cancel, R9 idempotent ask and stray release
    step(5, 1, 5, 1);
    step(0, 0, 5, 2);
    step(5, 2, 0, 0);
    check_all("R7 withdrawn wait not granted");
    step(0, 0, 2, 1);
    step(2, 2, 2, 1);
    check_all("R9 stray release and holder re-ask");

    free_all();

    // Near-exhaustive sweep: 5 states x 9 action pairs
    for (int s = 0; s < 5; s++) begin
      for (int c = 0; c < 9; c++) begin
        int k;
        k = (s * 9 + c) % N;
        step(k, 2, k, 2);
        case (s)
          1: step(k, 1, 0, 0);
          2: begin step(k, 1, 0, 0); step(0, 0, k, 1); end
          3: step(0, 0, k, 1);
          4: begin step(0, 0, k, 1); step(k, 1, 0, 0); end
          default: ;
        endcase
        step(k, c / 3, k, c % 3);
        check_all("R5 R6 R7 R9 R10 sweep");
      end
    end

    // Pseudo-random run across all semaphores
    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(int'(lfsr[2:0]), int'(lfsr[4:3]) % 3, int'(lfsr[7:5]), int'(lfsr[9:8]) % 3);
      if (n % 10 == 9) check_all("R4 R10 R11 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule